// File: doc/BRIEF.md
# Processor Power Mode Controller

This block owns the power-mode special register of a processor core. Software writes the register through the special-register bus, which carries an address built from a group and an index. A write that requests a low-power mode stops the core clock and, depending on the mode, the clocks of the tick timer and the interrupt controller. The block then watches the interrupt lines and restarts the core when a wake condition is met.

Three low-power modes are decoded from the written value. In doze, the core stops and the timer and interrupt controller keep running. In sleep, every unit stops. In suspend, every unit stops and nothing but reset brings the core back. When an interrupt wakes the core, the doze and sleep bits clear themselves. The block also hands the core a resume address: the instruction after the halting write, so the write does not run again. A unit-present word can be read at its own address, and it flags this unit as present.

The clock-gate enables and the halt output are registered. The clock cells themselves, the clock divider that would use the slow-down field, and the pipeline are outside the block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a synchronous reset, the mode register is zero, `core_halt` is 0, all three clock enables are 1, and `slow_factor` and `dyn_gate_en` are 0.
- R2: The mode register answers only at address (8 << 11) + 0 = 0x4000. A write there stores bits [7:0] of the data. A read there returns those 8 bits zero-extended, one cycle after `spr_re`. A write to any other address leaves the register and the outputs unchanged. Bits [3:0] (slow-down factor) appear on `slow_factor` and bit 6 (dynamic gating) appears on `dyn_gate_en`; neither bit halts the core.
- R3: A write to the mode register while the core runs, with bit 4 (doze), bit 5 (sleep) or bit 7 (suspend) set, raises `core_halt` on the same clock edge that stores the value.
- R4: Doze mode (bit 4 set, bits 5 and 7 clear): `core_clk_en` is 0, while `tick_clk_en` and `pic_clk_en` stay 1.
- R5: Sleep mode (bit 5 set, bit 7 clear): all three clock enables are 0. Sleep takes priority over doze when both bits are written together.
- R6: Suspend mode (bit 7 set): all three clock enables are 0, interrupts do not wake the core, and only reset ends the mode. Suspend takes priority over sleep and doze.
- R7: In doze or sleep, an interrupt that is both pending and enabled wakes the core on the next edge. On that edge, bits 4 and 5 clear, the other bits are kept, all enables return to 1, and `wake_evt` pulses for one cycle.
- R8: A halting write captures `wr_pc + 4` on `resume_pc`.
- R9: A pending interrupt whose `irq_mask` bit is 0 leaves the core halted.
- R10: A read at the unit-present address (0 << 11) + 1 = 0x0001 returns 0x0000_0201: bit 0 is the general present flag and bit 9 is the power-unit present flag.
- R11: Mode-register writes that arrive while the core is halted are ignored.
- R12: An enabled interrupt level that is already pending during the halting write is kept, not lost. The core halts for exactly one cycle and then wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_addr | input | ADDR_W | Special-register address, (group << 11) + index |
| spr_we | input | 1 | Write strobe |
| spr_re | input | 1 | Read strobe |
| spr_wdata | input | XLEN | Write data |
| wr_pc | input | XLEN | PC of the instruction issuing the write |
| irq_pending | input | NIRQ | Level interrupt requests, held by their sources |
| irq_mask | input | NIRQ | Interrupt enables, 1 = enabled |
| spr_rdata | output | XLEN | Registered read data |
| core_halt | output | 1 | Core is stopped |
| core_clk_en | output | 1 | Core clock enable |
| tick_clk_en | output | 1 | Tick timer clock enable |
| pic_clk_en | output | 1 | Interrupt controller clock enable |
| resume_pc | output | XLEN | Address at which execution resumes after a wake |
| wake_evt | output | 1 | One-cycle pulse on an interrupt wake |
| slow_factor | output | 4 | Slow-down field of the register |
| dyn_gate_en | output | 1 | Dynamic clock-gating bit of the register |

## Verification
The bench writes all 256 values of the low byte and checks each against a model of the mode priority. Getting the priority wrong would keep the peripheral clocks running in sleep, or let an interrupt end suspend. Each value is followed by a masked interrupt and then an unmasked one. A design that ignored the mask would wake too early. A design that cleared the wrong bits on wake would return a bad read-back. The resume address is checked against the write PC plus four; a design that kept the write PC would put the core straight back to sleep. Further directed cases cover an interrupt already pending during the halting write, which a faulty design would lose, writes issued while halted, and writes to neighbouring addresses.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int PMR_W       = 8;
  localparam int SDF_LSB     = 0;
  localparam int SDF_W       = 4;
  localparam int BIT_DOZE    = 4;
  localparam int BIT_SLEEP   = 5;
  localparam int BIT_DYNGATE = 6;
  localparam int BIT_SUSP    = 7;

  localparam int GRP_SHIFT   = 11;
  localparam int PMR_GROUP   = 8;
  localparam int PMR_INDEX   = 0;
  localparam int UPR_GROUP   = 0;
  localparam int UPR_INDEX   = 1;

  localparam int UPR_BIT_ANY = 0;
  localparam int UPR_BIT_PM  = 9;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_DOZE  = 2'd1,
    PM_SLEEP = 2'd2,
    PM_SUSP  = 2'd3
  } pm_state_e;

  function automatic int spr_index(input int grp, input int idx);
    return (grp << GRP_SHIFT) + idx;
  endfunction
endpackage

// File: rtl/pmc_spr_decode.sv
module pmc_spr_decode #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  output logic              pmr_wr,
  output logic              pmr_rd,
  output logic              upr_rd
);
  import pmc_pkg::*;

  localparam logic [ADDR_W-1:0] PMR_ADDR = ADDR_W'(spr_index(PMR_GROUP, PMR_INDEX));
  localparam logic [ADDR_W-1:0] UPR_ADDR = ADDR_W'(spr_index(UPR_GROUP, UPR_INDEX));

  logic hit_pmr, hit_upr;

  always_comb begin
    hit_pmr = (addr == PMR_ADDR);
    hit_upr = (addr == UPR_ADDR);
    pmr_wr  = we & hit_pmr;
    pmr_rd  = re & hit_pmr;
    upr_rd  = re & hit_upr;
  end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm #(
  parameter int XLEN = 32,
  parameter int NIRQ = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pmr_wr,
  input  logic [pmc_pkg::PMR_W-1:0] wdata,
  input  logic [XLEN-1:0]          wr_pc,
  input  logic [NIRQ-1:0]          irq_pending,
  input  logic [NIRQ-1:0]          irq_mask,
  output logic [pmc_pkg::PMR_W-1:0] pmr_q,
  output pmc_pkg::pm_state_e       state_q,
  output pmc_pkg::pm_state_e       state_d,
  output logic [XLEN-1:0]          resume_pc,
  output logic                     wake_evt
);
  import pmc_pkg::*;

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic [PMR_W-1:0] pmr_d;
  logic [XLEN-1:0]  resume_d;
  logic             wake_d;
  logic             irq_hit;

  always_comb begin
    irq_hit  = |(irq_pending & irq_mask);
    state_d  = state_q;
    pmr_d    = pmr_q;
    resume_d = resume_pc;
    wake_d   = 1'b0;
    case (state_q)
      PM_RUN: begin
        if (pmr_wr) begin
          pmr_d = wdata;
          if (wdata[BIT_SUSP])       state_d = PM_SUSP;
          else if (wdata[BIT_SLEEP]) state_d = PM_SLEEP;
          else if (wdata[BIT_DOZE])  state_d = PM_DOZE;
          if (wdata[BIT_SUSP] | wdata[BIT_SLEEP] | wdata[BIT_DOZE])
            resume_d = wr_pc + INSN_BYTES;
        end
      end
      PM_DOZE, PM_SLEEP: begin
        if (irq_hit) begin
          state_d          = PM_RUN;
          pmr_d[BIT_DOZE]  = 1'b0;
          pmr_d[BIT_SLEEP] = 1'b0;
          wake_d           = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PM_RUN;
      pmr_q     <= '0;
      resume_pc <= '0;
      wake_evt  <= 1'b0;
    end else begin
      state_q   <= state_d;
      pmr_q     <= pmr_d;
      resume_pc <= resume_d;
      wake_evt  <= wake_d;
    end
  end

  AST_SUSP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_SUSP) |=> (state_q == PM_SUSP)); // R6
  AST_HALTED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (state_q != PM_RUN && !irq_hit) |=> $stable(pmr_q)); // R11
endmodule

// File: rtl/pmc_gate_ctrl.sv
module pmc_gate_ctrl (
  input  logic               clk,
  input  logic               rst,
  input  pmc_pkg::pm_state_e state_d,
  output logic               core_halt,
  output logic               core_clk_en,
  output logic               tick_clk_en,
  output logic               pic_clk_en
);
  import pmc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_halt   <= 1'b0;
      core_clk_en <= 1'b1;
      tick_clk_en <= 1'b1;
      pic_clk_en  <= 1'b1;
    end else begin
      core_halt   <= (state_d != PM_RUN);
      core_clk_en <= (state_d == PM_RUN);
      tick_clk_en <= (state_d == PM_RUN) || (state_d == PM_DOZE);
      pic_clk_en  <= (state_d == PM_RUN) || (state_d == PM_DOZE);
    end
  end

  AST_PERIPH_PAIRED: assert property (@(posedge clk) disable iff (rst)
    tick_clk_en == pic_clk_en); // R4
  AST_CORE_NEEDS_PERIPH: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> (tick_clk_en && !core_halt)); // R5
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int ADDR_W = 16,
  parameter int XLEN   = 32,
  parameter int NIRQ   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] spr_addr,
  input  logic              spr_we,
  input  logic              spr_re,
  input  logic [XLEN-1:0]   spr_wdata,
  input  logic [XLEN-1:0]   wr_pc,
  input  logic [NIRQ-1:0]   irq_pending,
  input  logic [NIRQ-1:0]   irq_mask,
  output logic [XLEN-1:0]   spr_rdata,
  output logic              core_halt,
  output logic              core_clk_en,
  output logic              tick_clk_en,
  output logic              pic_clk_en,
  output logic [XLEN-1:0]   resume_pc,
  output logic              wake_evt,
  output logic [3:0]        slow_factor,
  output logic              dyn_gate_en
);
  import pmc_pkg::*;

  localparam logic [XLEN-1:0] UPR_WORD =
    (XLEN'(1) << UPR_BIT_ANY) | (XLEN'(1) << UPR_BIT_PM);
  localparam logic [ADDR_W-1:0] PMR_ADDR = ADDR_W'(spr_index(PMR_GROUP, PMR_INDEX));

  logic             pmr_wr, pmr_rd, upr_rd;
  logic [PMR_W-1:0] pmr_q;
  pm_state_e        state_q, state_d;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^spr_wdata[XLEN-1:PMR_W];

  pmc_spr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (spr_addr),
    .we     (spr_we),
    .re     (spr_re),
    .pmr_wr (pmr_wr),
    .pmr_rd (pmr_rd),
    .upr_rd (upr_rd)
  );

  pmc_mode_fsm #(.XLEN(XLEN), .NIRQ(NIRQ)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pmr_wr      (pmr_wr),
    .wdata       (spr_wdata[PMR_W-1:0]),
    .wr_pc       (wr_pc),
    .irq_pending (irq_pending),
    .irq_mask    (irq_mask),
    .pmr_q       (pmr_q),
    .state_q     (state_q),
    .state_d     (state_d),
    .resume_pc   (resume_pc),
    .wake_evt    (wake_evt)
  );

  pmc_gate_ctrl u_gate (
    .clk         (clk),
    .rst         (rst),
    .state_d     (state_d),
    .core_halt   (core_halt),
    .core_clk_en (core_clk_en),
    .tick_clk_en (tick_clk_en),
    .pic_clk_en  (pic_clk_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spr_rdata <= '0;
    end else if (spr_re) begin
      if (upr_rd)      spr_rdata <= UPR_WORD;
      else if (pmr_rd) spr_rdata <= XLEN'(pmr_q);
      else             spr_rdata <= '0;
    end
  end

  assign slow_factor = pmr_q[SDF_LSB +: SDF_W];
  assign dyn_gate_en = pmr_q[BIT_DYNGATE];

  AST_HALT_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (spr_we && spr_addr == PMR_ADDR && !core_halt &&
     (spr_wdata[BIT_DOZE] || spr_wdata[BIT_SLEEP] || spr_wdata[BIT_SUSP]))
    |=> core_halt); // R3
  AST_RESUME_NEXT: assert property (@(posedge clk) disable iff (rst)
    $rose(core_halt) |-> (resume_pc == $past(wr_pc) + XLEN'(4))); // R8
  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (core_halt && !(|(irq_pending & irq_mask))) |=> core_halt); // R9
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(core_halt) |-> (wake_evt && !pmr_q[BIT_DOZE] && !pmr_q[BIT_SLEEP])); // R7
endmodule

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
  localparam int XLEN = 32;
  localparam int NIRQ = 4;
  localparam logic [15:0] A_PMR = 16'h4000;
  localparam logic [15:0] A_UPR = 16'h0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] spr_addr = '0;
  logic spr_we = 1'b0, spr_re = 1'b0;
  logic [XLEN-1:0] spr_wdata = '0, wr_pc = '0;
  logic [NIRQ-1:0] irq_pending = '0, irq_mask = '0;
  logic [XLEN-1:0] spr_rdata, resume_pc;
  logic core_halt, core_clk_en, tick_clk_en, pic_clk_en, wake_evt, dyn_gate_en;
  logic [3:0] slow_factor;

  int vectors = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.ADDR_W(16), .XLEN(XLEN), .NIRQ(NIRQ)) uut (
    .clk(clk), .rst(rst), .spr_addr(spr_addr), .spr_we(spr_we), .spr_re(spr_re),
    .spr_wdata(spr_wdata), .wr_pc(wr_pc), .irq_pending(irq_pending),
    .irq_mask(irq_mask), .spr_rdata(spr_rdata), .core_halt(core_halt),
    .core_clk_en(core_clk_en), .tick_clk_en(tick_clk_en), .pic_clk_en(pic_clk_en),
    .resume_pc(resume_pc), .wake_evt(wake_evt), .slow_factor(slow_factor),
    .dyn_gate_en(dyn_gate_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq_pending = '0; irq_mask = '0; spr_we = 1'b0; spr_re = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [31:0] pc);
    @(negedge clk);
    spr_addr = a; spr_wdata = d; wr_pc = pc; spr_we = 1'b1;
    @(negedge clk);
    spr_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    spr_addr = a; spr_re = 1'b1;
    @(negedge clk);
    spr_re = 1'b0;
    d = spr_rdata;
  endtask

  task automatic chk_en(input string req, input logic c, input logic t, input logic p);
    chk(req, {29'd0, core_clk_en, tick_clk_en, pic_clk_en}, {29'd0, c, t, p});
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    do_reset();
    // R1 reset state
    chk("R1 halt", core_halt, 0);
    chk_en("R1 enables", 1, 1, 1);
    chk("R1 slow", slow_factor, 0);
    chk("R1 dyngate", dyn_gate_en, 0);
    rd(A_PMR, rv);
    chk("R1 pmr", rv, 0);
    // R10 presence word
    rd(A_UPR, rv);
    chk("R10 upr", rv, 32'h201);
    // R2 neighbour addresses untouched
    wr(16'h4001, 32'hFF, 32'h100);
    wr(16'h0000, 32'hFF, 32'h104);
    wr(16'hC000, 32'hFF, 32'h108);
    chk("R2 no halt", core_halt, 0);
    rd(A_PMR, rv);
    chk("R2 other addr", rv, 0);

    // exhaustive sweep over the low byte
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      logic hlt, sus, slp, doz, woke;
      logic [31:0] pc;
      b   = 8'(v);
      sus = b[7];
      slp = !sus && b[5];
      doz = !sus && !b[5] && b[4];
      hlt = sus | slp | doz;
      pc  = 32'h1000 + 32'(v) * 8;
      do_reset();
      wr(A_PMR, {24'd0, b}, pc);
      chk("R3 halt", core_halt, hlt);
      if (sus)      chk_en("R6 suspend enables", 0, 0, 0);
      else if (slp) chk_en("R5 sleep enables", 0, 0, 0);
      else if (doz) chk_en("R4 doze enables", 0, 1, 1);
      else          chk_en("R2 run enables", 1, 1, 1);
      if (hlt) chk("R8 resume", resume_pc, pc + 4);
      chk("R2 slow", slow_factor, b[3:0]);
      chk("R2 dyngate", dyn_gate_en, b[6]);
      rd(A_PMR, rv);
      chk("R2 readback", rv, {24'd0, b});
      // masked interrupt
      irq_pending = 4'b0100; irq_mask = 4'b1011;
      @(negedge clk);
      chk("R9 masked", core_halt, hlt);
      irq_mask = 4'b0100;
      @(negedge clk);
      woke = hlt && !sus;
      chk("R6/R7 halt after irq", core_halt, sus);
      chk("R7 wake pulse", wake_evt, woke);
      if (!sus) chk_en("R7 enables", 1, 1, 1);
      @(negedge clk);
      chk("R7 pulse one cycle", wake_evt, 0);
      irq_pending = '0; irq_mask = '0;
      rd(A_PMR, rv);
      chk("R7 bits after wake", rv, woke ? {24'd0, b & 8'hCF} : {24'd0, b});
    end

    // R11 writes while halted ignored
    do_reset();
    wr(A_PMR, 32'h13, 32'h2000);
    wr(A_PMR, 32'h00, 32'h3000);
    chk("R11 still halted", core_halt, 1);
    chk("R11 resume kept", resume_pc, 32'h2004);
    rd(A_PMR, rv);
    chk("R11 pmr kept", rv, 32'h13);
    wr(A_PMR, 32'h80, 32'h3004);
    chk_en("R11 doze enables kept", 0, 1, 1);

    // R12 interrupt already pending at the halting write
    do_reset();
    irq_pending = 4'b0001; irq_mask = 4'b0001;
    @(negedge clk);
    spr_addr = A_PMR; spr_wdata = 32'h10; wr_pc = 32'h4000; spr_we = 1'b1;
    @(negedge clk);
    spr_we = 1'b0;
    chk("R12 halts", core_halt, 1);
    @(negedge clk);
    chk("R12 wakes", core_halt, 0);
    chk("R12 pulse", wake_evt, 1);
    irq_pending = '0; irq_mask = '0;

    // R6 suspend ended only by reset
    do_reset();
    wr(A_PMR, 32'hB0, 32'h5000);
    irq_pending = 4'hF; irq_mask = 4'hF;
    repeat (5) @(negedge clk);
    chk("R6 suspend holds", core_halt, 1);
    do_reset();
    chk("R6 reset wakes", core_halt, 0);
    chk_en("R6 reset enables", 1, 1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule